// File: doc/BRIEF.md
# DMA Global Control and Status Register Block

This block holds the controller-wide registers of a multi-channel DMA engine: one control word, one word that combines interrupt status and interrupt mask, a priority word, a stall/quadword-count word, and the size and offset words of a ring buffer. It answers a register port that carries one request per cycle. A request is either a write, with enable, offset and data, or a read, with enable and offset. A read returns registered data together with a read-valid strobe. The block moves no data and raises no interrupt. It stores values, applies the clear-on-one rule to the status bits, and reads values back.

The port has no back-pressure. The block takes every request in the cycle it is presented, and the requester must not raise read and write in the same cycle. The status half of the combined word clears on a written one. The mask half is overwritten. Offsets that map to no register are absorbed: reads give zero and writes are dropped. A one-cycle flag marks each such access so that a monitor can count dropped traffic.

A separate comparator reports whether a physical address falls in the block's 4 KB-aligned page. A synchronous seed input loads the whole status word, so a test can create pending-interrupt bits.

Top module: `dma_glob_regs`

## Requirements
- R1: After reset every register reads as zero. A status read therefore shows no pending interrupt.
- R2: The control (offset 0x00), priority (0x20), stall/count (0x30), ring size (0x40) and ring offset (0x50) registers each return the last value written to them.
- R3: A write to the status register (offset 0x10) clears each bit of status[15:0] whose write-data bit is 1 and keeps each bit whose write-data bit is 0.
- R4: A write to the status register loads write-data[31:16] directly into status[31:16].
- R5: An offset with nonzero bits [3:0], or an aligned offset at 0x60 or above, is undefined. A read of it returns zero and a write to it changes no register.
- R6: A write to one register leaves every other register unchanged.
- R7: Read-valid is high in exactly the cycle after a cycle with read enable high, and read data holds the addressed value in that cycle.
- R8: The unmapped flag is high for one cycle, in the cycle after a read or write to an undefined offset. A defined access never raises it.
- R9: When the seed enable is high, the seed value loads the whole status word at the next edge. This takes precedence over a status write in the same cycle.
- R10: The window-hit output is high exactly when probe address bits [28:12] equal the same bits of the base parameter (default 0x1000E000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Write request |
| reg_off | input | 8 | Byte offset inside the window |
| reg_wdata | input | 32 | Write data |
| reg_re | input | 1 | Read request |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | Read response strobe |
| unmapped | output | 1 | One-cycle flag for an undefined-offset access |
| stat_seed_en | input | 1 | Test load of the status word |
| stat_seed_val | input | 32 | Value used by the test load |
| probe_addr | input | 29 | Physical address to classify |
| window_hit | output | 1 | Probe address is in this block's page |

## Verification
The assertions assume that read enable and write enable are never high together, that the offset and write data are stable and known whenever an enable is high, and that the seed input is used only to prepare a test. The bench drives every request at the falling edge and holds it for exactly one cycle. It never overlaps a read with a write, and it raises the seed enable together with a write only in the one case that tests seed precedence.

// File: rtl/dgr_pkg.sv
`timescale 1ns/1ps
package dgr_pkg;
  localparam int DGR_DW     = 32;
  localparam int DGR_OFF_W  = 8;
  localparam int DGR_NREG   = 6;
  localparam int DGR_STRIDE = 16;   // bytes between registers
  localparam int DGR_STAT   = 1;    // index of the status/mask word
  typedef enum logic [2:0] {
    RI_CTRL = 3'd0,
    RI_STAT = 3'd1,
    RI_PRIO = 3'd2,
    RI_SQWC = 3'd3,
    RI_RBSZ = 3'd4,
    RI_RBOF = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/dgr_decode.sv
`timescale 1ns/1ps
module dgr_decode #(
  parameter int OFF_W  = 8,
  parameter int NREG   = 6,
  parameter int STRIDE = 16,
  parameter int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [OFF_W-1:0] off,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  localparam int LSB = $clog2(STRIDE);
  localparam int SLOT_W = OFF_W - LSB;
  localparam logic [SLOT_W-1:0] NREG_V = SLOT_W'(NREG);

  logic [SLOT_W-1:0] slot;
  assign slot = off[OFF_W-1:LSB];
  assign hit  = (off[LSB-1:0] == '0) && (slot < NREG_V);
  assign idx  = slot[IDX_W-1:0];
endmodule

// File: rtl/dgr_window.sv
`timescale 1ns/1ps
module dgr_window #(
  parameter int          AW   = 29,
  parameter int          PG   = 12,
  parameter logic [28:0] BASE = 29'h1000_E000
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  assign hit = (addr[AW-1:PG] == BASE[AW-1:PG]);
endmodule

// File: rtl/dgr_regfile.sv
`timescale 1ns/1ps
module dgr_regfile #(
  parameter int DW    = 32,
  parameter int NREG  = 6,
  parameter int STAT  = 1,
  parameter int IDX_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic                      hit,
  input  logic [IDX_W-1:0]          idx,
  input  logic [DW-1:0]             wdata,
  input  logic                      seed_en,
  input  logic [DW-1:0]             seed_val,
  output logic [NREG-1:0][DW-1:0]   q
);
  localparam int HALF = DW / 2;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic sel;
    assign sel = we && hit && (idx == IDX_W'(i));
    if (i == STAT) begin : g_stat
      always_ff @(posedge clk) begin
        if (!rst_n)       q[i] <= '0;
        else if (seed_en) q[i] <= seed_val;
        else if (sel)     q[i] <= {wdata[DW-1:HALF], q[i][HALF-1:0] & ~wdata[HALF-1:0]};
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)   q[i] <= '0;
        else if (sel) q[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/dma_glob_regs.sv
`timescale 1ns/1ps
module dma_glob_regs
  import dgr_pkg::*;
#(
  parameter int          DW     = DGR_DW,
  parameter int          OFF_W  = DGR_OFF_W,
  parameter int          NREG   = DGR_NREG,
  parameter int          STRIDE = DGR_STRIDE,
  parameter int          AW     = 29,
  parameter logic [28:0] BASE   = 29'h1000_E000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [OFF_W-1:0] reg_off,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             reg_re,
  output logic [DW-1:0]    reg_rdata,
  output logic             reg_rvalid,
  output logic             unmapped,
  input  logic             stat_seed_en,
  input  logic [DW-1:0]    stat_seed_val,
  input  logic [AW-1:0]    probe_addr,
  output logic             window_hit
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic                    off_hit;
  logic [IDX_W-1:0]        off_idx;
  logic [NREG-1:0][DW-1:0] regs_q;
  logic [DW-1:0]           rd_mux;
  logic [DW-1:0]           stat_word;

  dgr_decode #(.OFF_W(OFF_W), .NREG(NREG), .STRIDE(STRIDE), .IDX_W(IDX_W)) u_dec (
    .off (reg_off),
    .hit (off_hit),
    .idx (off_idx)
  );

  dgr_regfile #(.DW(DW), .NREG(NREG), .STAT(DGR_STAT), .IDX_W(IDX_W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .hit      (off_hit),
    .idx      (off_idx),
    .wdata    (reg_wdata),
    .seed_en  (stat_seed_en),
    .seed_val (stat_seed_val),
    .q        (regs_q)
  );

  dgr_window #(.AW(AW), .BASE(BASE)) u_win (
    .addr (probe_addr),
    .hit  (window_hit)
  );

  assign stat_word = regs_q[DGR_STAT];

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (off_hit && off_idx == IDX_W'(i)) rd_mux = regs_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
      unmapped   <= 1'b0;
    end else begin
      reg_rvalid <= reg_re;
      unmapped   <= (reg_re || reg_we) && !off_hit;
      if (reg_re) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dgr_chk.sv
`timescale 1ns/1ps
module dgr_chk #(
  parameter int DW    = 32,
  parameter int OFF_W = 8,
  parameter int NREG  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             reg_re,
  input logic [OFF_W-1:0] reg_off,
  input logic [DW-1:0]    reg_wdata,
  input logic [DW-1:0]    reg_rdata,
  input logic             reg_rvalid,
  input logic             unmapped,
  input logic             stat_seed_en,
  input logic [DW-1:0]    stat_seed_val,
  input logic [DW-1:0]    stat_word
);
  localparam int HALF = DW / 2;
  localparam logic [OFF_W-1:0] STAT_OFF = OFF_W'(16);

  logic defined;
  assign defined = (reg_off[3:0] == 4'd0) && (int'(reg_off[OFF_W-1:4]) < NREG);

  always_comb begin
    if (rst_n) p_no_overlap_r7: assert (!(reg_we && reg_re));
  end

  p_rvalid_after_re_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> reg_rvalid);
  p_rvalid_only_re_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |=> !reg_rvalid);
  p_undef_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && !defined) |=> reg_rdata == '0);
  p_flag_undef_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_re || reg_we) && !defined) |=> unmapped);
  p_flag_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !((reg_re || reg_we) && !defined) |=> !unmapped);
  p_w1c_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_off == STAT_OFF && !stat_seed_en) |=>
      stat_word[HALF-1:0] == ($past(stat_word[HALF-1:0]) & ~$past(reg_wdata[HALF-1:0])));
  p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_off == STAT_OFF && !stat_seed_en) |=>
      stat_word[DW-1:HALF] == $past(reg_wdata[DW-1:HALF]));
  p_seed_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_seed_en |=> stat_word == $past(stat_seed_val));
  p_stat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_seed_en && !(reg_we && reg_off == STAT_OFF)) |=> $stable(stat_word));
endmodule

bind dma_glob_regs dgr_chk #(.DW(DW), .OFF_W(OFF_W), .NREG(NREG)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_we        (reg_we),
  .reg_re        (reg_re),
  .reg_off       (reg_off),
  .reg_wdata     (reg_wdata),
  .reg_rdata     (reg_rdata),
  .reg_rvalid    (reg_rvalid),
  .unmapped      (unmapped),
  .stat_seed_en  (stat_seed_en),
  .stat_seed_val (stat_seed_val),
  .stat_word     (stat_word)
);

// File: tb/dma_glob_regs_tb.sv
`timescale 1ns/1ps
module dma_glob_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_off = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_re = 1'b0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        unmapped;
  logic        stat_seed_en = 1'b0;
  logic [31:0] stat_seed_val = '0;
  logic [28:0] probe_addr = '0;
  logic        window_hit;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dma_glob_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_off(reg_off),
    .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .unmapped(unmapped),
    .stat_seed_en(stat_seed_en), .stat_seed_val(stat_seed_val),
    .probe_addr(probe_addr), .window_hit(window_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // write: drive at falling edge, captured at next rising edge; flag sampled one falling edge later
  task automatic wr(input logic [7:0] off, input logic [31:0] d, input string req, input bit exp_unm);
    reg_we = 1'b1; reg_off = off; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
    check({req, " unmapped flag on write"}, {31'd0, unmapped}, {31'd0, exp_unm});
  endtask

  task automatic rd(input logic [7:0] off, input logic [31:0] exp, input string req, input bit exp_unm);
    reg_re = 1'b1; reg_off = off;
    @(posedge clk); @(negedge clk);
    reg_re = 1'b0;
    check("R7 read valid", {31'd0, reg_rvalid}, 32'd1);
    check(req, reg_rdata, exp);
    check("R8 unmapped flag on read", {31'd0, unmapped}, {31'd0, exp_unm});
    @(posedge clk); @(negedge clk);
    check("R7 valid drops", {31'd0, reg_rvalid}, 32'd0);
  endtask

  task automatic seed(input logic [31:0] v);
    stat_seed_en = 1'b1; stat_seed_val = v;
    @(posedge clk); @(negedge clk);
    stat_seed_en = 1'b0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 6; i++) rd(8'(i * 16), 32'd0, "R1 reset value", 1'b0);
  endtask

  task automatic t_latches;
    wr(8'h00, 32'hC0DE_0001, "R2", 1'b0);
    wr(8'h20, 32'h0000_2222, "R2", 1'b0);
    wr(8'h30, 32'h3333_0303, "R2", 1'b0);
    wr(8'h40, 32'h4444_0404, "R2", 1'b0);
    wr(8'h50, 32'h5555_0505, "R2", 1'b0);
    rd(8'h00, 32'hC0DE_0001, "R2 control readback", 1'b0);
    rd(8'h20, 32'h0000_2222, "R2 priority readback", 1'b0);
    rd(8'h30, 32'h3333_0303, "R2 stall/count readback", 1'b0);
    rd(8'h40, 32'h4444_0404, "R2 ring size readback", 1'b0);
    rd(8'h50, 32'h5555_0505, "R2 ring offset readback", 1'b0);
  endtask

  task automatic t_independent;
    wr(8'h20, 32'hFFFF_FFFF, "R6", 1'b0);
    rd(8'h00, 32'hC0DE_0001, "R6 control untouched by priority write", 1'b0);
    rd(8'h10, 32'h0000_0000, "R6 status untouched", 1'b0);
    rd(8'h30, 32'h3333_0303, "R6 stall/count untouched", 1'b0);
  endtask

  task automatic t_status;
    seed(32'h1234_ABCD);
    rd(8'h10, 32'h1234_ABCD, "R9 seed loads status", 1'b0);
    wr(8'h10, 32'h5678_0F0F, "R3", 1'b0);
    rd(8'h10, 32'h5678_A0C0, "R3 R4 selective clear and mask load", 1'b0);
    wr(8'h10, 32'h0000_0000, "R3", 1'b0);
    rd(8'h10, 32'h0000_A0C0, "R3 zero keeps bits, R4 mask cleared", 1'b0);
    wr(8'h10, 32'hFFFF_FFFF, "R4", 1'b0);
    rd(8'h10, 32'hFFFF_0000, "R3 all cleared, R4 mask all ones", 1'b0);
    rd(8'h00, 32'hC0DE_0001, "R6 control after status writes", 1'b0);
  endtask

  task automatic t_seed_priority;
    stat_seed_en = 1'b1; stat_seed_val = 32'h0000_00FF;
    reg_we = 1'b1; reg_off = 8'h10; reg_wdata = 32'hFFFF_FFFF;
    @(posedge clk); @(negedge clk);
    stat_seed_en = 1'b0; reg_we = 1'b0;
    rd(8'h10, 32'h0000_00FF, "R9 seed over same-cycle write", 1'b0);
  endtask

  task automatic t_undefined;
    wr(8'h80, 32'hDEAD_BEEF, "R8", 1'b1);
    wr(8'h04, 32'hDEAD_BEEF, "R8", 1'b1);
    wr(8'h60, 32'hDEAD_BEEF, "R8", 1'b1);
    rd(8'h80, 32'd0, "R5 read of 0x80", 1'b1);
    rd(8'h04, 32'd0, "R5 read of misaligned 0x04", 1'b1);
    rd(8'h60, 32'd0, "R5 read of 0x60", 1'b1);
    rd(8'h00, 32'hC0DE_0001, "R5 control after undefined writes", 1'b0);
    rd(8'h10, 32'h0000_00FF, "R5 status after undefined writes", 1'b0);
    rd(8'h50, 32'h5555_0505, "R5 ring offset after undefined writes", 1'b0);
    @(posedge clk); @(negedge clk);
    check("R8 flag is one cycle", {31'd0, unmapped}, 32'd0);
  endtask

  task automatic t_window;
    probe_addr = 29'h1000_E050; #1;
    check("R10 in window", {31'd0, window_hit}, 32'd1);
    probe_addr = 29'h1000_EFFC; #1;
    check("R10 top of page", {31'd0, window_hit}, 32'd1);
    probe_addr = 29'h1000_D000; #1;
    check("R10 page below", {31'd0, window_hit}, 32'd0);
    probe_addr = 29'h1000_F000; #1;
    check("R10 page above", {31'd0, window_hit}, 32'd0);
    probe_addr = 29'h0000_E000; #1;
    check("R10 bit 28 differs", {31'd0, window_hit}, 32'd0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 no valid after reset", {31'd0, reg_rvalid}, 32'd0);
    check("R8 no flag after reset", {31'd0, unmapped}, 32'd0);
    t_reset();
    t_latches();
    t_independent();
    t_status();
    t_seed_priority();
    t_undefined();
    t_window();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule